// File: doc/BRIEF.md
# Serial Audio Transmit Framer (I2S / TDM)

This block is the transmit side of a serial audio port acting as bus master. It takes parallel samples through a ready/valid handshake and drives the bit clock, the frame clock and the serial data line. The block is clocked at twice the bit rate, so one bit period is exactly two cycles of `clk`. A small state machine with the states IDLE, LOW and HIGH is the bit-clock phase itself. Its transitions are: start (IDLE to LOW when `tx_en` is high), rise (LOW to HIGH), advance (HIGH to LOW, which moves to the next bit position) and stop (any state to IDLE when `tx_en` is low).

Two framings are offered. In left/right framing a frame has two channels, and the frame clock marks which channel is active. In pulse framing a frame has up to eight slots, and a sync pulse of programmable width opens it. A per-slot enable mask chooses which slots carry samples. Each slot holds a container window that starts a programmable number of bit clocks into the slot. Inside that window the sample bits go out first, in the order set by `lsb_first`, and zero bits fill the rest of the window. The data and frame clock change on the falling or the rising bit-clock edge, as `drive_fall` selects. The data line either drives all the time, floats outside the window, or floats half a bit clock after the last window bit. All control inputs are expected to stay stable while `tx_en` is high.

Top module: `tx_framer`

## Requirements
- R1: The FSM moves IDLE->LOW on start, LOW->HIGH and HIGH->LOW while `tx_en` is high. `bclk` is 1 only in HIGH, so a bit period is two `clk` cycles. The bit position advances on each HIGH->LOW transition.
- R2: With `frame_sel`=0 (left/right framing) a frame has two slots, each `chan_bits` bit periods long. `fclk` equals (slot index is 1) XOR `lr_pol`, so `lr_pol`=0 puts `fclk` low during the left slot.
- R3: With `frame_sel`=1 (pulse framing) a frame has `slot_last`+1 slots. `fclk` is high for bit positions 0 to `sync_w` of slot 0, so the pulse is `sync_w`+1 bit periods wide when `sync_w` < `chan_bits`.
- R4: The container length is C = 4*(`cont_code`+1), so codes 1 to 7 give 8 to 32 bits. The sample width is W = C − `cut_bits`. The window covers bit positions `data_off` to `data_off`+C−1 of a slot and is cut off at the slot end. Window positions j = 0 to W−1 carry the sample; all other positions send 0.
- R5: With `lsb_first`=0 window position j sends sample bit W−1−j (MSB first). With `lsb_first`=1 it sends sample bit j.
- R6: With `drive_fall`=1, `sdo`, `fclk` and `sdo_oe` change when `bclk` falls, and a bit is shown in its own LOW and HIGH cycles. With `drive_fall`=0 they change when `bclk` rises, and a bit is shown in its HIGH cycle and the following LOW cycle.
- R7: `hiz_mode` 0 keeps `sdo_oe`=1. Mode 1 sets `sdo_oe` only inside the window. Mode 2 (and 3) also keeps driving for the first half of the bit period that follows a window bit. When idle, `sdo_oe` = (`hiz_mode`==0).
- R8: `s_ready` is high for one cycle at the start of every enabled slot, and the sample is taken at that edge. Slot n is enabled when `slot_mask[n]` is 1 (left/right framing enables both slots). A disabled slot takes no sample and sends no window.
- R9: If `s_valid` is low when a slot's sample is taken, that slot sends zeros and `underflow` is high for exactly the next cycle. Frame timing keeps running.
- R10: After reset or when `tx_en` is low, the block goes to IDLE at the next edge. In IDLE, `bclk`, `fclk`, `sdo` and `s_ready` are 0 and the frame restarts at slot 0, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| frame_sel | input | 1 | 0 left/right framing, 1 pulse framing |
| lr_pol | input | 1 | Frame clock polarity for left/right framing |
| cont_code | input | 3 | Container size code |
| cut_bits | input | 3 | Bits removed from the container to form the sample width |
| chan_bits | input | 11 | Bit periods per slot |
| data_off | input | 11 | Window start inside a slot |
| sync_w | input | 8 | Sync pulse width minus one |
| slot_last | input | 3 | Slot count minus one, pulse framing |
| slot_mask | input | 8 | Per-slot enable |
| lsb_first | input | 1 | Bit order select |
| drive_fall | input | 1 | 1 change on falling edge, 0 on rising edge |
| hiz_mode | input | 2 | Data line float policy |
| s_valid | input | 1 | Sample available |
| s_data | input | 32 | Sample, right-justified |
| s_ready | output | 1 | Sample taken at this edge |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock or sync pulse |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | Data line output enable |
| underflow | output | 1 | One-cycle pulse, slot started without a sample |

## Verification
Two functions can fall in the same bit period. One is the half-bit release of the previous window in float mode 2. The other is the first bit of the next slot, where a sample may be fetched or the slot may be disabled. A pulse-framed case with the window filling the whole slot forces this overlap at an enabled slot and at a disabled one. Each half of those bit periods is compared against a model: the output enable must stay high in both halves when the next slot is enabled, and must drop in the second half when it is disabled. The same per-half comparison is run with the rising drive edge, where the release lands in the HIGH cycle rather than the LOW cycle.

// File: rtl/tx_pkg.sv
package tx_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOW  = 2'd1,
        S_HIGH = 2'd2
    } tx_state_e;

    localparam logic FRAME_LR   = 1'b0;
    localparam logic FRAME_SYNC = 1'b1;

    localparam logic [1:0] HZ_DRIVE  = 2'd0;
    localparam logic [1:0] HZ_WINDOW = 2'd1;
endpackage

// File: rtl/tx_bitpos.sv
module tx_bitpos #(
    parameter int CNT_W  = 11,
    parameter int NSLOT  = 8,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic [CNT_W-1:0]  chan_bits,
    input  logic [SLOT_W-1:0] slot_last,
    input  logic [NSLOT-1:0]  slot_en,
    input  logic              win_now,
    output logic [CNT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_live,
    output logic              prev_win,
    output logic              load_due
);
    logic [CNT_W-1:0]  last_bit;
    logic              wrap;
    logic [CNT_W-1:0]  nxt_bit;
    logic [SLOT_W-1:0] nxt_slot;
    logic              nxt_live;

    always_comb begin
        last_bit = (chan_bits == '0) ? '0 : chan_bits - 1'b1;
        wrap     = (bit_idx >= last_bit);
        if (restart) begin
            nxt_bit  = '0;
            nxt_slot = '0;
        end else begin
            nxt_bit  = wrap ? '0 : bit_idx + 1'b1;
            nxt_slot = !wrap ? slot_idx :
                       (slot_idx >= slot_last) ? '0 : slot_idx + 1'b1;
        end
        nxt_live = slot_en[nxt_slot];
        load_due = (restart || wrap) && nxt_live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx   <= '0;
            slot_idx  <= '0;
            slot_live <= 1'b0;
            prev_win  <= 1'b0;
        end else if (restart || step) begin
            bit_idx   <= nxt_bit;
            slot_idx  <= nxt_slot;
            slot_live <= nxt_live;
            prev_win  <= restart ? 1'b0 : win_now;
        end
    end
endmodule

// File: rtl/tx_bitsel.sv
module tx_bitsel #(
    parameter int DW    = 32,
    parameter int CNT_W = 11
) (
    input  logic [CNT_W-1:0] bit_idx,
    input  logic [CNT_W-1:0] data_off,
    input  logic [2:0]       cont_code,
    input  logic [2:0]       cut_bits,
    input  logic             lsb_first,
    input  logic             slot_live,
    input  logic [DW-1:0]    sample,
    output logic             in_win,
    output logic             bit_val
);
    localparam int IDX_W = (DW > 1) ? $clog2(DW) : 1;

    logic [7:0]       cont_len;
    logic [7:0]       samp_len;
    logic [CNT_W-1:0] rel;
    logic             in_samp;
    logic [CNT_W-1:0] pos;

    always_comb begin
        cont_len = ({5'd0, cont_code} + 8'd1) << 2;
        samp_len = (cont_len > {5'd0, cut_bits}) ? cont_len - {5'd0, cut_bits} : 8'd0;
        rel      = bit_idx - data_off;
        in_win   = slot_live && (bit_idx >= data_off) && (rel < CNT_W'(cont_len));
        in_samp  = in_win && (rel < CNT_W'(samp_len));
        pos      = lsb_first ? rel : CNT_W'(samp_len) - 1'b1 - rel;
        bit_val  = in_samp && (pos < CNT_W'(DW)) && sample[pos[IDX_W-1:0]];
    end
endmodule

// File: rtl/tx_framer.sv
module tx_framer
    import tx_pkg::*;
#(
    parameter int DW     = 32,
    parameter int CNT_W  = 11,
    parameter int SYNC_W = 8,
    parameter int NSLOT  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tx_en,
    input  logic                     frame_sel,
    input  logic                     lr_pol,
    input  logic [2:0]               cont_code,
    input  logic [2:0]               cut_bits,
    input  logic [CNT_W-1:0]         chan_bits,
    input  logic [CNT_W-1:0]         data_off,
    input  logic [SYNC_W-1:0]        sync_w,
    input  logic [$clog2(NSLOT)-1:0] slot_last,
    input  logic [NSLOT-1:0]         slot_mask,
    input  logic                     lsb_first,
    input  logic                     drive_fall,
    input  logic [1:0]               hiz_mode,
    input  logic                     s_valid,
    input  logic [DW-1:0]            s_data,
    output logic                     s_ready,
    output logic                     bclk,
    output logic                     fclk,
    output logic                     sdo,
    output logic                     sdo_oe,
    output logic                     underflow
);
    localparam int SLOT_W = $clog2(NSLOT);

    tx_state_e state, state_nxt;

    logic              restart, step, load_due;
    logic [CNT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx, slot_last_eff;
    logic [NSLOT-1:0]  slot_en_eff;
    logic              slot_live, prev_win, in_win, bit_val, f_now;
    logic [DW-1:0]     sample_q;
    logic              d_q, w_q, pw_q, f_q;
    logic              d_sel, w_sel, pw_sel, f_sel, first_half;

    // phase state machine: IDLE -> LOW -> HIGH -> LOW ...
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  state_nxt = tx_en ? S_LOW  : S_IDLE;
            S_LOW:   state_nxt = tx_en ? S_HIGH : S_IDLE;
            S_HIGH:  state_nxt = tx_en ? S_LOW  : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    assign restart       = (state == S_IDLE) && tx_en;
    assign step          = (state == S_HIGH) && tx_en;
    assign slot_last_eff = (frame_sel == FRAME_LR) ? SLOT_W'(1) : slot_last;
    assign slot_en_eff   = (frame_sel == FRAME_LR) ? '1 : slot_mask;
    assign s_ready       = load_due && (restart || step);

    tx_bitpos #(.CNT_W(CNT_W), .NSLOT(NSLOT), .SLOT_W(SLOT_W)) u_pos (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .chan_bits(chan_bits), .slot_last(slot_last_eff), .slot_en(slot_en_eff),
        .win_now(in_win), .bit_idx(bit_idx), .slot_idx(slot_idx),
        .slot_live(slot_live), .prev_win(prev_win), .load_due(load_due)
    );

    tx_bitsel #(.DW(DW), .CNT_W(CNT_W)) u_sel (
        .bit_idx(bit_idx), .data_off(data_off), .cont_code(cont_code),
        .cut_bits(cut_bits), .lsb_first(lsb_first), .slot_live(slot_live),
        .sample(sample_q), .in_win(in_win), .bit_val(bit_val)
    );

    // sample capture and starvation flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q  <= '0;
            underflow <= 1'b0;
        end else begin
            underflow <= s_ready && !s_valid;
            if (s_ready) sample_q <= s_valid ? s_data : '0;
        end
    end

    always_comb begin
        if (frame_sel == FRAME_LR) f_now = (slot_idx == SLOT_W'(1)) ^ lr_pol;
        else f_now = (slot_idx == '0) && (bit_idx <= CNT_W'(sync_w));
    end

    // half-bit delayed copy used for rising-edge drive
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_q <= 1'b0; w_q <= 1'b0; pw_q <= 1'b0; f_q <= 1'b0;
        end else if (state == S_IDLE) begin
            d_q <= 1'b0; w_q <= 1'b0; pw_q <= 1'b0; f_q <= 1'b0;
        end else if (state == S_LOW) begin
            d_q <= bit_val; w_q <= in_win; pw_q <= prev_win; f_q <= f_now;
        end
    end

    // output decode
    always_comb begin
        d_sel      = drive_fall ? bit_val  : d_q;
        w_sel      = drive_fall ? in_win   : w_q;
        pw_sel     = drive_fall ? prev_win : pw_q;
        f_sel      = drive_fall ? f_now    : f_q;
        first_half = drive_fall ? (state == S_LOW) : (state == S_HIGH);
        bclk = 1'b0; fclk = 1'b0; sdo = 1'b0;
        sdo_oe = (hiz_mode == HZ_DRIVE);
        if (state != S_IDLE) begin
            bclk = (state == S_HIGH);
            fclk = f_sel;
            if (hiz_mode == HZ_DRIVE)       sdo_oe = 1'b1;
            else if (hiz_mode == HZ_WINDOW) sdo_oe = w_sel;
            else                            sdo_oe = w_sel || (pw_sel && first_half);
            sdo = sdo_oe && d_sel;
        end
    end
endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk
    import tx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tx_en,
    input tx_state_e state,
    input logic      bclk,
    input logic      s_ready,
    input logic      s_valid,
    input logic      underflow,
    input logic      sdo_oe,
    input logic [1:0] hiz_mode
);
    a_r1_high_then_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HIGH) |=> !bclk);
    a_r1_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOW && tx_en) |=> bclk);
    a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state == S_IDLE && !bclk));
    a_r8_take_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> (state == S_LOW));
    a_r9_flag_on_starve: assert property (@(posedge clk) disable iff (!rst_n)
        (s_ready && !s_valid) |=> underflow);
    a_r9_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && !s_valid) |=> !underflow);
    a_r7_idle_float: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && hiz_mode != 2'd0) |-> !sdo_oe);
endmodule

bind tx_framer tx_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .state(state), .bclk(bclk),
    .s_ready(s_ready), .s_valid(s_valid), .underflow(underflow),
    .sdo_oe(sdo_oe), .hiz_mode(hiz_mode)
);

// File: tb/sim_tx_framer.sv
module sim_tx_framer;
    localparam int CLK_PERIOD = 10;
    localparam int MAXN = 256;

    logic        clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0;
    logic        frame_sel = 1'b0, lr_pol = 1'b0, lsb_first = 1'b0, drive_fall = 1'b1;
    logic [2:0]  cont_code = 3'd3, cut_bits = 3'd0, slot_last = 3'd1;
    logic [10:0] chan_bits = 11'd16, data_off = 11'd0;
    logic [7:0]  sync_w = 8'd0, slot_mask = 8'h03;
    logic [1:0]  hiz_mode = 2'd0;
    logic        s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_ready, bclk, fclk, sdo, sdo_oe, underflow;

    int n_vec = 0, n_bad = 0;
    logic ob_sdo[MAXN], ob_oe[MAXN], ob_fclk[MAXN], ob_bclk[MAXN];

    tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_sel(frame_sel),
        .lr_pol(lr_pol), .cont_code(cont_code), .cut_bits(cut_bits),
        .chan_bits(chan_bits), .data_off(data_off), .sync_w(sync_w),
        .slot_last(slot_last), .slot_mask(slot_mask), .lsb_first(lsb_first),
        .drive_fall(drive_fall), .hiz_mode(hiz_mode), .s_valid(s_valid),
        .s_data(s_data), .s_ready(s_ready), .bclk(bclk), .fclk(fclk),
        .sdo(sdo), .sdo_oe(sdo_oe), .underflow(underflow)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] samp_word(int i);
        return 32'h6B3D91C5 ^ (32'(i + 1) * 32'h9E3779B1);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // run nb bit periods with current settings, then stop and check idle
    task automatic run_scn(input string dtag, input int nb);
        int taken, flags, idx, c, w, ns, fl;
        bit rdy, pw;
        logic [31:0] cur;
        taken = 0; flags = 0; idx = 0; pw = 0; cur = '0;
        @(negedge clk);
        s_data = samp_word(0);
        tx_en = 1'b1;
        #1 rdy = s_ready;
        for (int n = 0; n <= 2*nb; n++) begin
            @(negedge clk);
            if (rdy) begin taken++; s_data = samp_word(taken); end
            ob_sdo[n] = sdo; ob_oe[n] = sdo_oe; ob_fclk[n] = fclk; ob_bclk[n] = bclk;
            if (n <= 2*nb-2 && underflow) flags++;
            rdy = (n <= 2*nb-3) ? s_ready : 1'b0;
        end
        tx_en = 1'b0;
        @(negedge clk);
        chk(bclk == 0 && fclk == 0 && sdo == 0 && s_ready == 0, "R10", "stop idle outs", {bclk, fclk, sdo, s_ready}, 0);
        chk(sdo_oe == (hiz_mode == 2'd0), "R7", "idle oe", sdo_oe, hiz_mode == 2'd0);
        // model
        c = (int'(cont_code) + 1) * 4;
        w = c - int'(cut_bits);
        ns = frame_sel ? int'(slot_last) + 1 : 2;
        fl = 0;
        for (int k = 0; k < nb; k++) begin
            int slot, b, j, s0;
            bit en, win, bv, f, oe1, oe2;
            slot = (k / int'(chan_bits)) % ns;
            b = k % int'(chan_bits);
            en = frame_sel ? slot_mask[slot] : 1'b1;
            if (b == 0 && en) begin
                cur = s_valid ? samp_word(idx) : 32'h0;
                idx++;
                if (!s_valid) fl++;
            end
            j = b - int'(data_off);
            win = en && b >= int'(data_off) && j < c;
            bv = win && j < w && (lsb_first ? cur[j] : cur[w-1-j]);
            f = frame_sel ? (slot == 0 && b <= int'(sync_w)) : ((slot == 1) ^ lr_pol);
            oe1 = (hiz_mode == 0) ? 1'b1 : (hiz_mode == 1) ? win : (win || pw);
            oe2 = (hiz_mode == 0) ? 1'b1 : win;
            s0 = drive_fall ? 2*k : 2*k+1;
            chk(ob_sdo[s0] == bv && ob_sdo[s0+1] == bv, dtag, $sformatf("sdo bit %0d", k), {ob_sdo[s0], ob_sdo[s0+1]}, {bv, bv});
            chk(ob_fclk[s0] == f && ob_fclk[s0+1] == f, frame_sel ? "R3" : "R2", $sformatf("fclk bit %0d", k), {ob_fclk[s0], ob_fclk[s0+1]}, {f, f});
            chk(ob_oe[s0] == oe1 && ob_oe[s0+1] == oe2, "R7", $sformatf("oe bit %0d", k), {ob_oe[s0], ob_oe[s0+1]}, {oe1, oe2});
            pw = win;
        end
        for (int n = 0; n < 2*nb; n++)
            chk(ob_bclk[n] == n[0], "R1", $sformatf("bclk half %0d", n), ob_bclk[n], n[0]);
        chk(taken == idx, "R8", "samples taken", taken, idx);
        chk(flags == fl, "R9", "underflow pulses", flags, fl);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(bclk == 0 && fclk == 0 && sdo == 0, "R10", "reset outs", {bclk, fclk, sdo}, 0);
        chk(s_ready == 0 && underflow == 0, "R10", "reset handshake", {s_ready, underflow}, 0);
        chk(sdo_oe == 1, "R7", "reset oe mode0", sdo_oe, 1);
    endtask

    task automatic t_lr_plain();   // R2 R4: 16-bit stereo, MSB first, no offset
        frame_sel = 0; lr_pol = 0; cont_code = 3; cut_bits = 0; chan_bits = 16;
        data_off = 0; lsb_first = 0; drive_fall = 1; hiz_mode = 0; s_valid = 1;
        run_scn("R4", 64);
    endtask

    task automatic t_lr_offset();  // R4 R7: offset 1, 12-bit sample in 16 container
        frame_sel = 0; lr_pol = 1; cont_code = 3; cut_bits = 4; chan_bits = 20;
        data_off = 1; lsb_first = 0; drive_fall = 1; hiz_mode = 1; s_valid = 1;
        run_scn("R4", 80);
    endtask

    task automatic t_tdm_overlap(); // R3 R5 R8: release and next slot start coincide
        frame_sel = 1; slot_last = 3; slot_mask = 8'b0000_1011; sync_w = 1;
        cont_code = 1; cut_bits = 0; chan_bits = 8; data_off = 0; lsb_first = 1;
        drive_fall = 1; hiz_mode = 2; s_valid = 1;
        run_scn("R5", 64);
    endtask

    task automatic t_rise_edge();   // R6: rising-edge drive with half-bit release
        frame_sel = 0; lr_pol = 0; cont_code = 2; cut_bits = 1; chan_bits = 14;
        data_off = 1; lsb_first = 0; drive_fall = 0; hiz_mode = 2; s_valid = 1;
        run_scn("R6", 56);
    endtask

    task automatic t_starve();      // R9: no samples, zeros and pulses
        frame_sel = 1; slot_last = 2; slot_mask = 8'b0000_0011; sync_w = 0;
        cont_code = 1; cut_bits = 0; chan_bits = 10; data_off = 2; lsb_first = 0;
        drive_fall = 1; hiz_mode = 0; s_valid = 0;
        run_scn("R9", 60);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_lr_plain();
        t_lr_offset();
        t_tdm_overlap();
        t_rise_edge();
        t_starve();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule